// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit watchdog counter with a single keyed configuration register and a small flag register on a simple 16-bit register bus. Two count-enable inputs stand for two clock domains already brought onto the system clock. A configuration bit picks which of them advances the counter. The counter itself cannot be read or written from the bus. Software can only restart it, freeze it, or change the length of the interval.

In supervision mode, an expiry asks the system reset controller for a reset, which is a one-cycle pulse on `rst_req`. In interval mode, an expiry sets a maskable interrupt flag and counting goes on. The flag is cleared by a write-one to the flag register or by the interrupt acknowledge. The configuration register accepts only writes that carry the write key 0x5A in the upper byte. A write with any other upper byte is taken as a sign of runaway software: the register keeps its value and a reset is requested at once. On a read, the upper byte always shows 0x69.

Top module: `wdog_ivt`

## Requirements
- R1: After reset the configuration register reads 0x6900 (supervision mode, not held, source 0, tap code 0), the flag register reads 0, and `rst_req` and `irq_flag` are low.
- R2: A read at address 0 returns 0x69 in bits 15:8. The lower byte holds hold (bit 7), mode (bit 4), source (bit 2) and tap code (bits 1:0). Bits 6, 5 and 3 read 0.
- R3: A write to address 0 whose bits 15:8 equal 0x5A loads hold, mode, source and tap code from bits 7, 4, 2 and 1:0. The new values are readable in the next cycle.
- R4: A write to address 0 whose bits 15:8 differ from 0x5A leaves the register unchanged and raises `rst_req` for exactly one cycle after the write edge.
- R5: When not held, the counter advances once per cycle in which the selected count enable is high. Source 0 selects `src0_tick` and source 1 selects `src1_tick`. The other enable has no effect.
- R6: Measured from a restart, an expiry occurs on the 2^15, 2^13, 2^9 or 2^6-th counted tick for tap codes 0, 1, 2 and 3. The counter then restarts from zero and keeps counting.
- R7: A valid-key write with bit 3 set restarts the counter from zero, even if a tick arrives in the same cycle. Bit 3 is not stored.
- R8: While hold is 1, the counter does not advance and no expiry occurs.
- R9: In supervision mode (mode 0), an expiry raises `rst_req` for one cycle and leaves the flag unchanged.
- R10: In interval mode (mode 1), an expiry sets `irq_flag` in the cycle after the expiring tick and does not raise `rst_req`.
- R11: Writing address 1 with bit 0 set clears the flag without a key. Writing bit 0 as 0 has no effect. A high `irq_ack` clears the flag. An expiry in the same cycle wins over either clear. Reads of address 1 return the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src0_tick | input | 1 | Count enable for clock source 0 |
| src1_tick | input | 1 | Count enable for clock source 1 |
| bus_addr | input | 1 | Register select: 0 configuration, 1 flag |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr`, combinational |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_flag | output | 1 | Interval interrupt flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The checker takes for granted that each bus write lasts one cycle with stable data. It also assumes the count enables are plain synchronous levels, so a tick in the same cycle as a configuration write is legal and must lose to the restart. The stimulus changes every input only at the falling clock edge. It holds a count enable high for long runs so that interval lengths can be counted exactly, and it always restarts the counter in the same write that changes mode or tap. It releases hold with a write that does not restart, which exposes a counter that was frozen rather than cleared.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int         BUS_W  = 16;
   localparam logic [7:0] WR_KEY = 8'h5A;
   localparam logic [7:0] RD_KEY = 8'h69;
   localparam int         HOLD_B = 7;
   localparam int         MODE_B = 4;
   localparam int         CLR_B  = 3;
   localparam int         SRC_B  = 2;

   typedef struct packed {
      logic       hold;
      logic       mode;   // 1: interval, 0: supervision
      logic       src;
      logic [1:0] tap;
   } wdt_cfg_t;

   localparam wdt_cfg_t CFG_RESET = '0;

   function automatic logic [7:0] cfg_byte(wdt_cfg_t c);
      logic [7:0] b;
      b         = '0;
      b[HOLD_B] = c.hold;
      b[MODE_B] = c.mode;
      b[SRC_B]  = c.src;
      b[1:0]    = c.tap;
      return b;
   endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
   import wdt_pkg::*;
#(
   parameter logic [7:0] KEY = WR_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wdata,
   output wdt_cfg_t          cfg_q,
   output logic              clr_pulse,
   output logic              key_bad
);
   logic key_ok;
   logic unused_wdata;

   assign key_ok       = (wdata[BUS_W-1 -: 8] == KEY);
   assign key_bad      = wr_en && !key_ok;
   assign clr_pulse    = wr_en && key_ok && wdata[CLR_B];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (wr_en && key_ok) begin
         cfg_q.hold <= wdata[HOLD_B];
         cfg_q.mode <= wdata[MODE_B];
         cfg_q.src  <= wdata[SRC_B];
         cfg_q.tap  <= wdata[1:0];
      end
   end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int CW    = 16,
   parameter int TAP_0 = 15,
   parameter int TAP_1 = 13,
   parameter int TAP_2 = 9,
   parameter int TAP_3 = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src0_tick,
   input  logic          src1_tick,
   input  logic          src,
   input  logic          hold,
   input  logic          clr,
   input  logic [1:0]    tap,
   output logic [CW-1:0] cnt_q,
   output logic          expire
);
   localparam int NTAP = 4;
   localparam int TAPS [NTAP] = '{TAP_0, TAP_1, TAP_2, TAP_3};

   logic [NTAP-1:0] hit;
   logic            tick;

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      if (TAPS[i] < 1 || TAPS[i] >= CW) begin : g_bad
         $error("wdt_count: tap %0d out of range for counter width %0d", TAPS[i], CW);
      end
      localparam logic [CW-1:0] MASK = CW'((64'd1 << TAPS[i]) - 64'd1);
      assign hit[i] = ((cnt_q & MASK) == MASK);
   end

   assign tick   = src ? src1_tick : src0_tick;
   assign expire = tick && !hold && !clr && hit[tap];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (tick && !hold) begin
         cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic mode,
   input  logic key_bad,
   input  logic flag_clr,
   input  logic irq_ack,
   output logic rst_req,
   output logic irq_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         rst_req <= key_bad || (expire && !mode);
         if (expire && mode)
            irq_flag <= 1'b1;
         else if (flag_clr || irq_ack)
            irq_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/wdog_ivt.sv
module wdog_ivt
   import wdt_pkg::*;
#(
   parameter int         CW    = 16,
   parameter int         TAP_0 = 15,
   parameter int         TAP_1 = 13,
   parameter int         TAP_2 = 9,
   parameter int         TAP_3 = 6,
   parameter logic [7:0] KEY_W = WR_KEY,
   parameter logic [7:0] KEY_R = RD_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src0_tick,
   input  logic              src1_tick,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              irq_ack,
   output logic              irq_flag,
   output logic              rst_req
);
   if (CW < 8) begin : g_bad_cw
      $error("wdog_ivt: counter width %0d too small", CW);
   end

   wdt_cfg_t      cfg_q;
   logic          clr_pulse;
   logic          key_bad;
   logic          expire;
   logic [CW-1:0] cnt_q;
   logic          cfg_wr;
   logic          flag_clr;

   assign cfg_wr   = bus_wr && (bus_addr == 1'b0);
   assign flag_clr = bus_wr && (bus_addr == 1'b1) && bus_wdata[0];

   wdt_cfg_reg #(.KEY(KEY_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .wdata     (bus_wdata),
      .cfg_q     (cfg_q),
      .clr_pulse (clr_pulse),
      .key_bad   (key_bad)
   );

   wdt_count #(
      .CW(CW), .TAP_0(TAP_0), .TAP_1(TAP_1), .TAP_2(TAP_2), .TAP_3(TAP_3)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .src0_tick (src0_tick),
      .src1_tick (src1_tick),
      .src       (cfg_q.src),
      .hold      (cfg_q.hold),
      .clr       (clr_pulse),
      .tap       (cfg_q.tap),
      .cnt_q     (cnt_q),
      .expire    (expire)
   );

   wdt_event u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .mode     (cfg_q.mode),
      .key_bad  (key_bad),
      .flag_clr (flag_clr),
      .irq_ack  (irq_ack),
      .rst_req  (rst_req),
      .irq_flag (irq_flag)
   );

   always_comb begin
      if (bus_addr == 1'b0)
         bus_rdata = {KEY_R, cfg_byte(cfg_q)};
      else
         bus_rdata = {{(BUS_W-1){1'b0}}, irq_flag};
   end
endmodule

// File: rtl/wdog_ivt_chk.sv
module wdog_ivt_chk
   import wdt_pkg::*;
#(
   parameter int CW = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_addr,
   input logic             bus_wr,
   input logic [BUS_W-1:0] bus_wdata,
   input logic [BUS_W-1:0] bus_rdata,
   input logic             irq_ack,
   input logic             irq_flag,
   input logic             rst_req,
   input logic             hold_q,
   input logic             mode_q,
   input logic             clr_pulse,
   input logic             expire,
   input logic [CW-1:0]    cnt_q
);
   logic bad_wr;
   assign bad_wr = bus_wr && !bus_addr && (bus_wdata[BUS_W-1 -: 8] != WR_KEY);

   a_r2_read_key: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> bus_rdata[15:8] == RD_KEY);

   a_r4_bad_key_reset: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> rst_req);

   a_r9_rst_source: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(bad_wr) || ($past(expire) && !$past(mode_q))));

   a_r10_flag_interval_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> ($past(expire) && $past(mode_q)));

   a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !clr_pulse) |=> $stable(cnt_q));

   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !expire) |=> !irq_flag);

   a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> cnt_q == '0);
endmodule

bind wdog_ivt wdog_ivt_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_ack   (irq_ack),
   .irq_flag  (irq_flag),
   .rst_req   (rst_req),
   .hold_q    (cfg_q.hold),
   .mode_q    (cfg_q.mode),
   .clr_pulse (clr_pulse),
   .expire    (expire),
   .cnt_q     (cnt_q)
);

// File: tb/sim_wdog_ivt.sv
module sim_wdog_ivt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src0_tick = 1'b0;
   logic        src1_tick = 1'b0;
   logic        bus_addr = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_ack = 1'b0;
   logic        irq_flag;
   logic        rst_req;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   wdog_ivt u0 (
      .clk(clk), .rst_n(rst_n), .src0_tick(src0_tick), .src1_tick(src1_tick),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_flag(irq_flag),
      .rst_req(rst_req)
   );

   // write data, expected configuration readback
   localparam logic [31:0] VEC [5] = '{
      {16'h5A80, 16'h6980},
      {16'h5A1F, 16'h6917},
      {16'h5A04, 16'h6904},
      {16'h5AFF, 16'h6997},
      {16'h5A93, 16'h6993}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd_chk(input logic a, input logic [15:0] exp, input string req);
      bus_addr = a;
      #1;
      chk(bus_rdata == exp, req, bus_rdata, exp);
   endtask

   // counts cycles from the last write edge to the first output event
   task automatic measure(input int exp_n, input bit on_rst, input string req);
      int first = 0;
      int highs = 0;
      int other = 0;
      for (int k = 1; k <= exp_n + 4; k++) begin
         @(negedge clk);
         if (on_rst ? rst_req : irq_flag) begin
            highs++;
            if (first == 0) first = k;
         end
         if (on_rst ? irq_flag : rst_req) other++;
      end
      chk(first == exp_n, req, first, exp_n);
      chk(other == 0, {req, " other output quiet"}, other, 0);
      if (on_rst) chk(highs == 1, {req, " single-cycle pulse"}, highs, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   initial begin
      int cnt;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_chk(1'b0, 16'h6900, "R1 ctrl reset");
      rd_chk(1'b1, 16'h0000, "R1 flag reset");
      chk(!rst_req && !irq_flag, "R1 outputs low", {rst_req, irq_flag}, 0);

      // R2/R3 vector table
      foreach (VEC[i]) begin
         wr(1'b0, VEC[i][31:16]);
         rd_chk(1'b0, VEC[i][15:0], "R2 R3 keyed write readback");
         chk(!rst_req, "R3 no reset on valid key", rst_req, 0);
      end

      // R4 bad key
      wr(1'b0, 16'h5A97);
      wr(1'b0, 16'h3C00);
      chk(rst_req, "R4 bad key reset request", rst_req, 1);
      rd_chk(1'b0, 16'h6997, "R4 ctrl unchanged");
      @(negedge clk);
      chk(!rst_req, "R4 one-cycle pulse", rst_req, 0);

      // R10/R6/R7 interval tap 3
      src0_tick = 1'b1;
      wr(1'b0, 16'h5A1B);
      measure(64, 1'b0, "R10 R6 tap3 interval");

      // R11 flag clear by write
      wr(1'b1, 16'h0000);
      chk(irq_flag, "R11 write zero no effect", irq_flag, 1);
      rd_chk(1'b1, 16'h0001, "R11 flag readback");
      wr(1'b1, 16'h0001);
      chk(!irq_flag, "R11 write one clears", irq_flag, 0);

      // R11 acknowledge
      wr(1'b0, 16'h5A1B);
      measure(64, 1'b0, "R10 tap3 again");
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(!irq_flag, "R11 ack clears", irq_flag, 0);

      // R7 restart mid-count
      wr(1'b0, 16'h5A1B);
      repeat (30) @(negedge clk);
      wr(1'b0, 16'h5A1B);
      measure(64, 1'b0, "R7 restart mid-count");
      wr(1'b1, 16'h0001);

      // R6 remaining taps
      wr(1'b0, 16'h5A1A);
      measure(512, 1'b0, "R6 tap2");
      wr(1'b1, 16'h0001);
      wr(1'b0, 16'h5A19);
      measure(8192, 1'b0, "R6 tap1");
      wr(1'b1, 16'h0001);
      wr(1'b0, 16'h5A18);
      measure(32768, 1'b0, "R6 tap0");
      wr(1'b1, 16'h0001);

      // R8 hold
      wr(1'b0, 16'h5A9B);
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (irq_flag) cnt++;
      end
      chk(cnt == 0, "R8 held counter no expiry", cnt, 0);
      wr(1'b0, 16'h5A13);
      measure(64, 1'b0, "R8 release resumes from frozen zero");
      wr(1'b1, 16'h0001);

      // R5 source select
      wr(1'b0, 16'h5A1F);
      cnt = 0;
      for (int k = 0; k < 150; k++) begin
         @(negedge clk);
         if (irq_flag) cnt++;
      end
      chk(cnt == 0, "R5 unselected source ignored", cnt, 0);
      src1_tick = 1'b1;
      measure(64, 1'b0, "R5 source 1 counts");
      src1_tick = 1'b0;
      wr(1'b1, 16'h0001);

      // R9 supervision and continuation
      wr(1'b0, 16'h5A0B);
      measure(64, 1'b1, "R9 supervision expiry");
      measure(60, 1'b1, "R6 R9 counter continues");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule